// File: doc/BRIEF.md
# Receive Checksum Verifier with Result Trailer

This block sits in a receive datapath after the MAC and checks the integrity fields of each incoming Ethernet frame while the frame streams through. Bytes enter one per beat on a valid/ready/last stream. The block reads the EtherType, the IPv4 version and header-length byte, the total length, the protocol number and the two addresses. It adds up the IPv4 header and the transport segment in one's-complement arithmetic as the bytes pass. Every input byte leaves unchanged and in order. The block then appends a 4-byte result trailer, and the end-of-frame marker moves onto the last trailer byte.

Each of the two trailer fields reads 0x0000 when its checksum was computed and is correct. It holds the nonzero one's-complement residue when the checksum is wrong. It reads 0xFFFF when the frame or protocol is unsupported, when the frame is too short to check, or when checking is switched off. A two-entry register interface holds a receive master enable and a word of per-protocol check enables. The block samples both at the first byte of each frame, so software can change them safely between frames. The master enable reads back as set until the frame in flight has left the block.

Top module: `rxck_verifier`

## Requirements
- R1: A frame of N input bytes leaves as N+4 output beats. The first N beats equal the input bytes in order. `m_last` is high only on beat N+4, and `s_last` is never forwarded.
- R2: Trailer beat order: the IPv4 header result low byte, then its high byte, then the transport result low byte, then its high byte.
- R3: A field whose checksum is correct holds 0x0000. A field whose checksum is wrong holds the bitwise inverse of the end-around-carry 16-bit sum of the covered bytes (even offsets are high bytes), which is never 0x0000.
- R4: For protocol 6 (TCP) and protocol 17 (UDP), the transport sum also covers the source and destination addresses (frame bytes 26 to 33), the protocol number and the transport length. The transport length is the total length minus 4*IHL.
- R5: For protocol 1 (ICMP), the transport sum covers only the transport bytes, with no address or length terms.
- R6: Check-enable register (address 1) bits: 0 for the IPv4 header, 4 for TCP, 5 for UDP, 6 for ICMP. Bits 20, 21 and 22 (IPv6 TCP, UDP, ICMP) are stored and read back. All other bits read 0. A cleared enable gives 0xFFFF in its field.
- R7: Only EtherType 0x0800 with version 4 and IHL of at least 5 is checked. EtherType 0x86DD (IPv6) and every other EtherType give 0xFFFF in both fields. An IPv4 protocol other than 1, 6 or 17 gives 0xFFFF in the transport field.
- R8: If the frame ends before 14+4*IHL bytes, both fields are 0xFFFF. If the frame ends before 14+total-length bytes, the transport field is 0xFFFF and the header result is still reported.
- R9: The master enable is bit 5 of the control register (address 0). It reads 1 while set or while a frame is still in flight, and 0 otherwise. Both registers are sampled at the first byte of a frame. With the master enable cleared, both fields are 0xFFFF.
- R10: The header sum spans 4*IHL bytes from byte 14, including options, and the transport segment starts at byte 14+4*IHL.
- R11: While `m_ready` is low the output beat is held unchanged. No input byte is accepted while the trailer is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_data | input | 8 | Input frame byte |
| s_valid | input | 1 | Input byte valid |
| s_last | input | 1 | Input byte is the last of its frame |
| s_ready | output | 1 | Block accepts an input byte |
| m_data | output | 8 | Output byte (frame data or trailer) |
| m_valid | output | 1 | Output byte valid |
| m_last | output | 1 | Output byte is the last trailer byte |
| m_ready | input | 1 | Downstream accepts an output byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 check enables |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |

## Verification
Two events can fall in the same cycle: a register write clearing the master enable or the check enables, and the byte flow of a frame already under way. The bench provokes this by writing both registers in the middle of a long frame. It then expects that frame's trailer to reflect the enables sampled at its first byte, and the busy readback to hold 1 until the trailer has left. A second overlap is downstream stall against the trailer handover: random `m_ready` gaps are applied across back-to-back frames, and the scoreboard compares every beat, including where `m_last` lands.

// File: rtl/rxck_pkg.sv
package rxck_pkg;
  // frame layout (byte offsets from the first destination-address byte)
  localparam int ETH_HDR_LEN = 14;
  localparam int OFS_ETYPE   = 12;
  localparam int OFS_VIHL    = 14;
  localparam int OFS_TLEN    = 16;
  localparam int OFS_PROTO   = 23;
  localparam int OFS_ADDR    = 26;
  localparam int ADDR_BYTES  = 8;

  localparam logic [15:0] ETYPE_V4 = 16'h0800;
  localparam logic [15:0] ETYPE_V6 = 16'h86DD;

  localparam logic [7:0] PROTO_ICMP = 8'd1;
  localparam logic [7:0] PROTO_TCP  = 8'd6;
  localparam logic [7:0] PROTO_UDP  = 8'd17;

  // check-enable register bit positions
  localparam int EB_IP4   = 0;
  localparam int EB_TCP4  = 4;
  localparam int EB_UDP4  = 5;
  localparam int EB_ICMP4 = 6;
  localparam int EB_TCP6  = 20;
  localparam int EB_UDP6  = 21;
  localparam int EB_ICMP6 = 22;
  localparam logic [31:0] CHK_MASK =
    (32'd1 << EB_IP4) | (32'd1 << EB_TCP4) | (32'd1 << EB_UDP4) |
    (32'd1 << EB_ICMP4) | (32'd1 << EB_TCP6) | (32'd1 << EB_UDP6) |
    (32'd1 << EB_ICMP6);

  // control register: receive master enable
  localparam int MASTER_BIT = 5;

  // per-frame enable snapshot, compacted
  localparam int FE_IP   = 0;
  localparam int FE_TCP  = 1;
  localparam int FE_UDP  = 2;
  localparam int FE_ICMP = 3;
  localparam int FE_W    = 4;

  // summing lanes
  localparam int LANE_HDR = 0;
  localparam int LANE_L4  = 1;
  localparam int LANE_PSH = 2;
  localparam int NUM_LANES = 3;

  localparam int TRL_BYTES = 4;

  typedef enum logic {ST_BODY, ST_TRAIL} rxck_state_t;

  // place a byte in its half of a 16-bit word: even offsets are high bytes
  function automatic logic [31:0] lane_word(input logic [7:0] b, input logic odd);
    return odd ? {24'd0, b} : {16'd0, b, 8'd0};
  endfunction

  // end-around-carry fold of a 32-bit accumulator into 16 bits
  function automatic logic [15:0] fold16(input logic [31:0] s);
    logic [16:0] t;
    logic [16:0] r;
    t = {1'b0, s[15:0]} + {1'b0, s[31:16]};
    r = {1'b0, t[15:0]} + {16'd0, t[16]};
    return r[15:0];
  endfunction

  // value reported in a trailer field: 0 when the covered data sums to all ones
  function automatic logic [15:0] residue(input logic [31:0] s);
    return ~fold16(s);
  endfunction
endpackage

// File: rtl/rxck_hdr_fields.sv
module rxck_hdr_fields
  import rxck_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             last,
  input  logic [7:0]       data,
  output logic [CNT_W-1:0] idx,
  output logic [CNT_W-1:0] flen,
  output logic [15:0]      etype,
  output logic [7:0]       vihl,
  output logic [15:0]      tlen,
  output logic [7:0]       proto
);
  localparam logic [CNT_W-1:0] IDX_MAX = '1;

  logic [CNT_W-1:0] idx_inc;
  assign idx_inc = (idx == IDX_MAX) ? idx : idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      flen  <= '0;
      etype <= '0;
      vihl  <= '0;
      tlen  <= '0;
      proto <= '0;
    end else if (beat) begin
      idx <= last ? '0 : idx_inc;
      if (last) flen <= idx_inc;
      // fields are cleared at the first byte so short frames leave no stale values
      if (idx == CNT_W'(OFS_ETYPE))          etype[15:8] <= data;
      else if (idx == '0)                    etype       <= '0;
      if (idx == CNT_W'(OFS_ETYPE + 1))      etype[7:0]  <= data;
      if (idx == CNT_W'(OFS_VIHL))           vihl        <= data;
      else if (idx == '0)                    vihl        <= '0;
      if (idx == CNT_W'(OFS_TLEN))           tlen[15:8]  <= data;
      else if (idx == '0)                    tlen        <= '0;
      if (idx == CNT_W'(OFS_TLEN + 1))       tlen[7:0]   <= data;
      if (idx == CNT_W'(OFS_PROTO))          proto       <= data;
      else if (idx == '0)                    proto       <= '0;
    end
  end
endmodule

// File: rtl/rxck_sum_lane.sv
module rxck_sum_lane
  import rxck_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        add,
  input  logic [7:0]  data,
  input  logic        odd,
  output logic [31:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n)     acc <= '0;
    else if (clr)   acc <= '0;
    else if (add)   acc <= acc + lane_word(data, odd);
  end
endmodule

// File: rtl/rxck_result.sv
module rxck_result
  import rxck_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [15:0]      etype,
  input  logic [7:0]       vihl,
  input  logic [15:0]      tlen,
  input  logic [7:0]       proto,
  input  logic [CNT_W-1:0] flen,
  input  logic [31:0]      acc_hdr,
  input  logic [31:0]      acc_l4,
  input  logic [31:0]      acc_psh,
  input  logic [FE_W-1:0]  fen,
  input  logic [1:0]       sel,
  output logic [15:0]      ip_res,
  output logic [15:0]      l4_res,
  output logic [7:0]       tbyte
);
  localparam int W1 = (CNT_W > 16 ? CNT_W : 16) + 1;

  logic [5:0]    hl;
  logic [W1-1:0] flen_x, need_hdr, need_l4;
  logic          is_v4, hdr_done, l4_done, l4_on, use_ph;
  logic [15:0]   l4_len;
  logic [31:0]   l4_sum;

  always_comb begin
    hl       = {vihl[3:0], 2'b00};
    flen_x   = W1'(flen);
    need_hdr = W1'(ETH_HDR_LEN) + W1'(hl);
    need_l4  = W1'(ETH_HDR_LEN) + W1'(tlen);
    is_v4    = (etype == ETYPE_V4) && (vihl[7:4] == 4'd4) && (vihl[3:0] >= 4'd5);
    hdr_done = flen_x >= need_hdr;
    l4_done  = hdr_done && (tlen >= 16'(hl)) && (flen_x >= need_l4);
    l4_len   = tlen - 16'(hl);
    case (proto)
      PROTO_TCP:  begin l4_on = fen[FE_TCP];  use_ph = 1'b1; end
      PROTO_UDP:  begin l4_on = fen[FE_UDP];  use_ph = 1'b1; end
      PROTO_ICMP: begin l4_on = fen[FE_ICMP]; use_ph = 1'b0; end
      default:    begin l4_on = 1'b0;         use_ph = 1'b0; end
    endcase
    l4_sum = acc_l4 + (use_ph ? (acc_psh + 32'(proto) + 32'(l4_len)) : 32'd0);
    ip_res = (is_v4 && hdr_done && fen[FE_IP]) ? residue(acc_hdr) : 16'hFFFF;
    l4_res = (is_v4 && l4_done && l4_on) ? residue(l4_sum) : 16'hFFFF;
    case (sel)
      2'd0:    tbyte = ip_res[7:0];
      2'd1:    tbyte = ip_res[15:8];
      2'd2:    tbyte = l4_res[7:0];
      default: tbyte = l4_res[15:8];
    endcase
  end
endmodule

// File: rtl/rxck_verifier.sv
module rxck_verifier
  import rxck_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  s_data,
  input  logic        s_valid,
  input  logic        s_last,
  output logic        s_ready,
  output logic [7:0]  m_data,
  output logic        m_valid,
  output logic        m_last,
  input  logic        m_ready,
  input  logic        reg_we,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int W1 = (CNT_W > 16 ? CNT_W : 16) + 1;
  localparam logic [1:0] TRL_LAST = 2'(TRL_BYTES - 1);

  rxck_state_t      st_q;
  logic [1:0]       trl_cnt;
  logic             master_q;
  logic [31:0]      chk_q;
  logic [FE_W-1:0]  fen_q;

  logic [CNT_W-1:0] idx, flen;
  logic [15:0]      etype, tlen;
  logic [7:0]       vihl, proto;
  logic [7:0]       trl_byte;
  logic [15:0]      ip_res, l4_res;

  // named events, also observed by the checker
  logic             s_beat, frame_start, trail_active, in_frame, trl_done;
  logic             in_hdr, in_l4, in_psh;
  logic [NUM_LANES-1:0] lane_add;
  logic [31:0]      lane_acc [NUM_LANES];

  logic [3:0]       ihl_now;
  logic [W1-1:0]    idx_x, hdr_end, l4_beg, l4_end;

  assign trail_active = (st_q == ST_TRAIL);
  assign s_ready      = !trail_active && m_ready;
  assign s_beat       = s_valid && s_ready;
  assign frame_start  = s_beat && (idx == '0);
  assign in_frame     = trail_active || (idx != '0);
  assign trl_done     = trail_active && m_ready && (trl_cnt == TRL_LAST);

  assign m_valid = trail_active ? 1'b1 : s_valid;
  assign m_data  = trail_active ? trl_byte : s_data;
  assign m_last  = trail_active && (trl_cnt == TRL_LAST);

  assign reg_rdata = reg_addr ? chk_q
                              : (32'(master_q || in_frame) << MASTER_BIT);

  rxck_hdr_fields #(.CNT_W(CNT_W)) u_fields (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (s_beat),
    .last  (s_last),
    .data  (s_data),
    .idx   (idx),
    .flen  (flen),
    .etype (etype),
    .vihl  (vihl),
    .tlen  (tlen),
    .proto (proto)
  );

  // byte windows for the three sums
  always_comb begin
    ihl_now = (idx == CNT_W'(OFS_VIHL)) ? s_data[3:0] : vihl[3:0];
    idx_x   = W1'(idx);
    hdr_end = W1'(ETH_HDR_LEN) + W1'({ihl_now, 2'b00});
    l4_beg  = W1'(ETH_HDR_LEN) + W1'({vihl[3:0], 2'b00});
    l4_end  = W1'(ETH_HDR_LEN) + W1'(tlen);
    in_hdr  = (idx_x >= W1'(ETH_HDR_LEN)) && (idx_x < hdr_end);
    in_l4   = (idx_x >= l4_beg) && (idx_x < l4_end);
    in_psh  = (idx_x >= W1'(OFS_ADDR)) && (idx_x < W1'(OFS_ADDR + ADDR_BYTES));
    lane_add = '0;
    lane_add[LANE_HDR] = s_beat && in_hdr;
    lane_add[LANE_L4]  = s_beat && in_l4;
    lane_add[LANE_PSH] = s_beat && in_psh;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    rxck_sum_lane u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (frame_start),
      .add   (lane_add[g]),
      .data  (s_data),
      .odd   (idx[0]),
      .acc   (lane_acc[g])
    );
  end

  rxck_result #(.CNT_W(CNT_W)) u_result (
    .etype   (etype),
    .vihl    (vihl),
    .tlen    (tlen),
    .proto   (proto),
    .flen    (flen),
    .acc_hdr (lane_acc[LANE_HDR]),
    .acc_l4  (lane_acc[LANE_L4]),
    .acc_psh (lane_acc[LANE_PSH]),
    .fen     (fen_q),
    .sel     (trl_cnt),
    .ip_res  (ip_res),
    .l4_res  (l4_res),
    .tbyte   (trl_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_BODY;
      trl_cnt  <= '0;
      master_q <= 1'b0;
      chk_q    <= '0;
      fen_q    <= '0;
    end else begin
      if (reg_we) begin
        if (reg_addr) chk_q    <= reg_wdata & CHK_MASK;
        else          master_q <= reg_wdata[MASTER_BIT];
      end
      if (frame_start) begin
        fen_q[FE_IP]   <= master_q && chk_q[EB_IP4];
        fen_q[FE_TCP]  <= master_q && chk_q[EB_TCP4];
        fen_q[FE_UDP]  <= master_q && chk_q[EB_UDP4];
        fen_q[FE_ICMP] <= master_q && chk_q[EB_ICMP4];
      end
      case (st_q)
        ST_BODY: if (s_beat && s_last) begin
          st_q    <= ST_TRAIL;
          trl_cnt <= '0;
        end
        default: if (m_ready) begin
          trl_cnt <= trl_cnt + 2'd1;
          if (trl_done) st_q <= ST_BODY;
        end
      endcase
    end
  end
endmodule

// File: rtl/rxck_verifier_chk.sv
module rxck_verifier_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_valid,
  input logic        s_ready,
  input logic        s_last,
  input logic        m_valid,
  input logic        m_ready,
  input logic        m_last,
  input logic [7:0]  m_data,
  input logic        reg_addr,
  input logic [31:0] reg_rdata,
  input logic        trail_active,
  input logic [1:0]  trl_cnt,
  input logic        in_frame
);
  // R1: the trailer starts right after the last input byte
  a_r1_trail_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last) |=> (trail_active && trl_cnt == 2'd0));

  // R1: after the final marked beat is taken the block is back to passing data
  a_r1_last_ends_trail: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_last) |=> !trail_active);

  // R2: trailer bytes advance one per accepted beat
  a_r2_trail_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_active && m_ready && trl_cnt != 2'd3) |=>
      (trail_active && trl_cnt == 2'($past(trl_cnt) + 2'd1)));

  // R11: a stalled trailer beat is held
  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_active && !m_ready) |=> (m_valid && $stable(m_data) && $stable(trl_cnt)));

  // R11: nothing enters while the trailer goes out
  a_r11_no_input_in_trail: assert property (@(posedge clk) disable iff (!rst_n)
    trail_active |-> !s_ready);

  // R9: control readback shows busy during a frame
  a_r9_busy_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !reg_addr) |-> reg_rdata[5]);
endmodule

bind rxck_verifier rxck_verifier_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .s_valid      (s_valid),
  .s_ready      (s_ready),
  .s_last       (s_last),
  .m_valid      (m_valid),
  .m_ready      (m_ready),
  .m_last       (m_last),
  .m_data       (m_data),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .trail_active (trail_active),
  .trl_cnt      (trl_cnt),
  .in_frame     (in_frame)
);

// File: tb/rxck_verifier_tb_top.sv
`timescale 1ns/1ps
module rxck_verifier_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  s_data;
  logic        s_valid, s_last, s_ready;
  logic [7:0]  m_data;
  logic        m_valid, m_last, m_ready;
  logic        reg_we, reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  always #2.5 clk = ~clk;

  rxck_verifier dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .m_data(m_data), .m_valid(m_valid), .m_last(m_last), .m_ready(m_ready),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  typedef struct packed { logic [7:0] d; logic l; } beat_t;
  beat_t       exp_q[$];
  string       tag_q[$];
  logic [7:0]  frm[$];
  int          n_checks = 0;
  int          n_errors = 0;
  bit          bp_mode  = 0;
  bit          m_master = 0;
  logic [31:0] m_chk    = '0;
  beat_t       mon_e;
  string       mon_t;
  bit          done     = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // downstream readiness
  always @(posedge clk) begin
    #0.5;
    m_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && m_valid && m_ready) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL R1: unexpected beat actual %h expected none", m_data);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        if (m_data !== mon_e.d || m_last !== mon_e.l) begin
          n_errors++;
          $display("FAIL %s: beat actual %h/%b expected %h/%b", mon_t, m_data, m_last, mon_e.d, mon_e.l);
        end
      end
    end
  end

  // bench-side one's-complement sum, folded but not inverted
  function automatic logic [15:0] bsum(int start, int len, logic [31:0] init);
    logic [31:0] s;
    s = init;
    for (int k = 0; k < len; k++)
      s += (k % 2 == 0) ? {16'd0, frm[start+k], 8'd0} : {24'd0, frm[start+k]};
    while (s[31:16] != 16'd0) s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    return s[15:0];
  endfunction

  // expected trailer fields from the requirements, {ip, l4}
  function automatic logic [31:0] model();
    logic [15:0] ip, l4;
    logic [7:0]  pr;
    logic        on;
    int          n, hl, tot;
    logic [31:0] init;
    ip = 16'hFFFF; l4 = 16'hFFFF; n = frm.size();
    if (m_master && n >= 15 && {frm[12], frm[13]} == 16'h0800 &&
        frm[14][7:4] == 4'd4 && frm[14][3:0] >= 4'd5) begin
      hl = 4 * int'(frm[14][3:0]);
      if (n >= 14 + hl) begin
        if (m_chk[0]) ip = ~bsum(14, hl, 32'd0);
        tot = int'({frm[16], frm[17]});
        pr  = frm[23];
        on  = (pr == 8'd6) ? m_chk[4] : (pr == 8'd17) ? m_chk[5] : (pr == 8'd1) ? m_chk[6] : 1'b0;
        if (on && tot >= hl && n >= 14 + tot) begin
          init = (pr == 8'd1) ? 32'd0 : {16'd0, bsum(26, 8, 32'd0)} + 32'(pr) + 32'(tot - hl);
          l4 = ~bsum(14 + hl, tot - hl, init);
        end
      end
    end
    return {ip, l4};
  endfunction

  task automatic build(logic [15:0] et, int ihl, logic [7:0] pr, int l4len);
    int hl, tot, base, co;
    logic [15:0] ck;
    logic [31:0] init;
    frm.delete();
    for (int k = 0; k < 6; k++) frm.push_back(8'(k + 2));
    for (int k = 0; k < 6; k++) frm.push_back(8'(k + 8'hA0));
    frm.push_back(et[15:8]); frm.push_back(et[7:0]);
    if (et == 16'h0800) begin
      hl = ihl * 4; tot = hl + l4len;
      frm.push_back(8'(8'h40 | ihl)); frm.push_back(8'h00);
      frm.push_back(8'(tot >> 8)); frm.push_back(8'(tot));
      frm.push_back(8'h1C); frm.push_back(8'h46); frm.push_back(8'h40); frm.push_back(8'h00);
      frm.push_back(8'h40); frm.push_back(pr); frm.push_back(8'h00); frm.push_back(8'h00);
      frm.push_back(8'h0A); frm.push_back(8'h00); frm.push_back(8'h00); frm.push_back(8'h01);
      frm.push_back(8'hC0); frm.push_back(8'hA8); frm.push_back(8'h01); frm.push_back(8'h07);
      for (int k = 0; k < hl - 20; k++) frm.push_back(8'h01);
      ck = ~bsum(14, hl, 32'd0); frm[24] = ck[15:8]; frm[25] = ck[7:0];
      base = 14 + hl;
      for (int k = 0; k < l4len; k++) frm.push_back(8'(k * 7 + 3));
      co = (pr == 8'd6) ? 16 : (pr == 8'd17) ? 6 : (pr == 8'd1) ? 2 : -1;
      if (co >= 0) begin
        if (pr == 8'd17) begin frm[base+4] = 8'(l4len >> 8); frm[base+5] = 8'(l4len); end
        frm[base+co] = 8'h00; frm[base+co+1] = 8'h00;
        init = (pr == 8'd1) ? 32'd0 : {16'd0, bsum(26, 8, 32'd0)} + 32'(pr) + 32'(l4len);
        ck = ~bsum(base, l4len, init);
        frm[base+co] = ck[15:8]; frm[base+co+1] = ck[7:0];
      end
    end else if (et == 16'h86DD) begin
      frm.push_back(8'h60);
      for (int k = 0; k < 39; k++) frm.push_back((k == 5) ? 8'd6 : 8'(k));
      for (int k = 0; k < 20; k++) frm.push_back(8'(k + 1));
    end else begin
      for (int k = 0; k < 28; k++) frm.push_back(8'(k + 5));
    end
  endtask

  // driver: queue the expected beats, then drive the frame
  task automatic send(string tag);
    logic [31:0] r;
    beat_t b;
    int n;
    r = model();
    n = frm.size();
    for (int i = 0; i < n; i++) begin b.d = frm[i]; b.l = 1'b0; exp_q.push_back(b); tag_q.push_back(tag); end
    b.l = 1'b0; b.d = r[23:16]; exp_q.push_back(b); tag_q.push_back(tag);   // R2 ip low
    b.d = r[31:24]; exp_q.push_back(b); tag_q.push_back(tag);               // ip high
    b.d = r[7:0];   exp_q.push_back(b); tag_q.push_back(tag);               // l4 low
    b.d = r[15:8];  b.l = 1'b1; exp_q.push_back(b); tag_q.push_back(tag);   // l4 high, last
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #0.5;
      s_valid = 1'b1; s_data = frm[i]; s_last = (i == n - 1);
      do @(negedge clk); while (!s_ready);
    end
    @(posedge clk); #0.5;
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic wr(logic a, logic [31:0] v);
    @(posedge clk); #0.5;
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(posedge clk); #0.5;
    reg_we = 1'b0;
  endtask

  task automatic rd(logic a, output logic [31:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic drain();
    int w;
    w = 0;
    while (exp_q.size() != 0 && w < 5000) begin @(posedge clk); w++; end
    check("R1 drain", 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; s_valid = 1'b0; s_last = 1'b0; s_data = '0;
    m_ready = 1'b1; reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset m_valid", 32'(m_valid), 32'd0);
    rd(1'b0, v); check("R9 reset control", v, 32'd0);
    rd(1'b1, v); check("R6 reset enables", v, 32'd0);
    @(posedge clk); #0.5; rst_n = 1'b1;

    // R6: enable bits stored, undefined bits dropped
    wr(1'b1, 32'hFFFF_FFFF); rd(1'b1, v); check("R6 enable readback", v, 32'h0070_0071);
    wr(1'b0, 32'h20); rd(1'b0, v); check("R9 master readback", v, 32'h20);
    m_master = 1; m_chk = 32'h0070_0071;

    build(16'h0800, 5, 8'd6, 24);  send("R4 tcp good");
    build(16'h0800, 5, 8'd17, 13); send("R4 udp odd length");
    build(16'h0800, 5, 8'd1, 16);  send("R5 icmp good");
    build(16'h0800, 5, 8'd6, 24);  frm[22] ^= 8'h5A; send("R3 header corrupt");
    build(16'h0800, 5, 8'd17, 20); frm[frm.size()-1] ^= 8'h01; send("R3 udp corrupt");
    build(16'h0800, 5, 8'd1, 12);  frm[40] ^= 8'h80; send("R3 icmp corrupt");
    build(16'h0800, 7, 8'd6, 30);  send("R10 options tcp");
    build(16'h0800, 6, 8'd17, 9);  send("R10 options udp");
    build(16'h86DD, 5, 8'd6, 0);   send("R7 ipv6");
    build(16'h0806, 5, 8'd0, 0);   send("R7 other ethertype");
    build(16'h0800, 5, 8'd47, 20); send("R7 unsupported protocol");
    build(16'h0800, 5, 8'd6, 24);  repeat (5) void'(frm.pop_back()); send("R8 short l4");
    build(16'h0800, 6, 8'd6, 24);  while (frm.size() > 30) void'(frm.pop_back()); send("R8 short header");
    drain();

    wr(1'b1, 32'h51); m_chk = 32'h51;
    build(16'h0800, 5, 8'd17, 20); send("R6 udp disabled");
    wr(1'b1, 32'h70); m_chk = 32'h70;
    build(16'h0800, 5, 8'd6, 20);  send("R6 ip disabled");
    wr(1'b1, 32'h71); m_chk = 32'h71;
    drain();

    bp_mode = 1;
    build(16'h0800, 5, 8'd6, 40);  send("R11 stall tcp");
    build(16'h0800, 5, 8'd1, 8);   send("R11 stall icmp");
    build(16'h0800, 6, 8'd17, 21); send("R11 stall udp");
    build(16'h0806, 5, 8'd0, 0);   send("R11 stall other");
    drain();
    bp_mode = 0;
    repeat (3) @(posedge clk);

    // R9: registers change mid-frame, the running frame keeps its snapshot
    build(16'h0800, 5, 8'd6, 40);
    fork
      send("R9 snapshot");
      begin
        repeat (10) @(posedge clk);
        wr(1'b0, 32'h0); wr(1'b1, 32'h0);
        rd(1'b0, v); check("R9 busy while frame in flight", v, 32'h20);
      end
    join
    m_master = 0; m_chk = 32'h0;
    drain();
    repeat (3) @(posedge clk);
    rd(1'b0, v); check("R9 idle after frame", v, 32'h0);
    build(16'h0800, 5, 8'd6, 24);  send("R9 master off");
    drain();
    wr(1'b0, 32'h20); m_master = 1;
    build(16'h0800, 5, 8'd6, 24);  send("R9 master on, checks off");
    drain();
    wr(1'b1, 32'h71); m_chk = 32'h71;
    build(16'h0800, 5, 8'd6, 24);  send("R9 re-enabled");
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule